// File: doc/BRIEF.md
# Delay Setting Phase Offset Adjuster

This block sits between a delay-locked loop and a delay chain. The loop supplies a coarse delay-chain setting. The block adds a small signed trim to that setting and returns the final control word for the chain. The trim comes from one of two places. It can be a signed constant fixed when the block is built. It can also be an unsigned magnitude arriving on a port at run time, which is always added, always subtracted, or added or subtracted under a direction input.

Two run-time frequency modes set the limits. In the wide mode the trim spans -64 to +63 and the delay word tops out at 64. In the three narrow modes the trim spans -32 to +31 and the ceiling is 32. The block limits the trim to the mode's span first. It then clamps the sum to the range from 0 to the ceiling and raises a flag in every cycle whose result was clamped. The output is registered.

A small controller has two states. `ST_RAW` is entered on reset and passes the loop setting through with no trim. The transition `RAW_TO_ADJUST` is taken unconditionally on the first clock after reset is released. `ST_ADJUST` then applies the trim on every clock. The only way back to `ST_RAW` is the transition `ANY_TO_RAW`, taken on reset.

Top module: `dly_ofs_adjust`

## Requirements
- R1: While reset is low, and on the first clock edge after it is released (state ST_RAW), `dly_set` takes the raw `dll_set` value with zero trim, and `clamp_flag` is 0.
- R2: With `ofs_src` = 0 (static), the trim is the STATIC_OFFSET parameter, limited to [-64, +63] in mode 0 and to [-32, +31] in modes 1 to 3.
- R3: With `ofs_src` = 1, the trim is +`ofs_mag` and `ofs_dir` is ignored.
- R4: With `ofs_src` = 2, the trim is -`ofs_mag` and `ofs_dir` is ignored.
- R5: With `ofs_src` = 3, the trim is +`ofs_mag` when `ofs_dir` = 1 and -`ofs_mag` when `ofs_dir` = 0.
- R6: When `freq_mode` = 0, a dynamic magnitude of up to 63 is used unaltered in both directions.
- R7: When `freq_mode` is 1, 2 or 3, a dynamic magnitude is limited to 31 when adding and to 32 when subtracting, before the sum is formed.
- R8: A sum above the ceiling (64 when `freq_mode` = 0, 32 otherwise) gives the ceiling.
- R9: A sum below 0 gives 0.
- R10: `clamp_flag` is 1 in exactly those cycles whose registered result was clamped by R8 or R9, and 0 in all other cycles.
- R11: `dly_set` and `clamp_flag` reflect the inputs sampled on the previous clock edge, including `freq_mode`, so a mode change takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_mode | input | 2 | 0 = wide mode; 1, 2 or 3 = narrow mode |
| ofs_src | input | 2 | 0 static, 1 add, 2 subtract, 3 direction controlled |
| ofs_dir | input | 1 | With ofs_src = 3: 1 adds, 0 subtracts |
| ofs_mag | input | 6 | Dynamic trim magnitude |
| dll_set | input | 7 | Delay setting from the locked loop |
| dly_set | output | 7 | Registered final delay-chain setting |
| clamp_flag | output | 1 | Registered; high when the result was clamped |

## Verification
Several properties are checked on every cycle. The raw pass-through in ST_RAW is checked, as is the rule that the output never exceeds the current mode's ceiling. Subtraction is checked never to raise the setting, and addition from an in-range setting never to lower it. A zero dynamic magnitude must leave the setting unchanged with the flag low, and a raised flag must always sit at a boundary value. Some results can only be shown by the bench's scenarios. These are the exact sums at and one past each limit, the narrow-mode limiting of both the static and the dynamic trim, the direction control, and the output following a mode change one clock later.

// File: rtl/dly_ofs_pkg.sv
package dly_ofs_pkg;

    typedef enum logic [1:0] {
        SRC_STATIC = 2'd0,
        SRC_ADD    = 2'd1,
        SRC_SUB    = 2'd2,
        SRC_BOTH   = 2'd3
    } src_e;

    typedef enum logic {
        ST_RAW    = 1'b0,
        ST_ADJUST = 1'b1
    } state_e;

endpackage

// File: rtl/dly_ofs_select.sv
module dly_ofs_select
    import dly_ofs_pkg::*;
#(
    parameter int OFS_W         = 8,
    parameter int MAG_W         = 6,
    parameter int WIDE_CEIL     = 64,
    parameter int NARROW_CEIL   = 32,
    parameter int STATIC_OFFSET = 3
) (
    input  logic                    narrow,
    input  src_e                    src,
    input  logic                    dir,
    input  logic [MAG_W-1:0]        mag,
    output logic signed [OFS_W-1:0] ofs
);
    localparam int W_ADD_MAX = WIDE_CEIL - 1;
    localparam int W_SUB_MAX = WIDE_CEIL;
    localparam int N_ADD_MAX = NARROW_CEIL - 1;
    localparam int N_SUB_MAX = NARROW_CEIL;

    int add_max, sub_max, mag_i, add_mag, sub_mag, stat_i, ofs_i;

    always_comb begin
        add_max = narrow ? N_ADD_MAX : W_ADD_MAX;
        sub_max = narrow ? N_SUB_MAX : W_SUB_MAX;
        mag_i   = int'(mag);
        add_mag = (mag_i > add_max) ? add_max : mag_i;
        sub_mag = (mag_i > sub_max) ? sub_max : mag_i;

        if (STATIC_OFFSET > add_max)       stat_i = add_max;
        else if (STATIC_OFFSET < -sub_max) stat_i = -sub_max;
        else                               stat_i = STATIC_OFFSET;

        unique case (src)
            SRC_STATIC: ofs_i = stat_i;
            SRC_ADD:    ofs_i = add_mag;
            SRC_SUB:    ofs_i = -sub_mag;
            SRC_BOTH:   ofs_i = dir ? add_mag : -sub_mag;
            default:    ofs_i = 0;
        endcase
        ofs = OFS_W'(ofs_i);
    end

endmodule

// File: rtl/dly_range_limit.sv
module dly_range_limit #(
    parameter int SET_W       = 7,
    parameter int OFS_W       = 8,
    parameter int WIDE_CEIL   = 64,
    parameter int NARROW_CEIL = 32
) (
    input  logic [SET_W-1:0]        dll,
    input  logic signed [OFS_W-1:0] ofs,
    input  logic                    narrow,
    output logic [SET_W-1:0]        res,
    output logic                    clamped
);
    int ceil_i, sum_i;

    always_comb begin
        ceil_i = narrow ? NARROW_CEIL : WIDE_CEIL;
        sum_i  = int'(dll) + int'(ofs);
        if (sum_i < 0) begin
            res     = '0;
            clamped = 1'b1;
        end else if (sum_i > ceil_i) begin
            res     = SET_W'(ceil_i);
            clamped = 1'b1;
        end else begin
            res     = SET_W'(sum_i);
            clamped = 1'b0;
        end
    end

endmodule

// File: rtl/dly_ofs_adjust.sv
module dly_ofs_adjust
    import dly_ofs_pkg::*;
#(
    parameter int SET_W         = 7,
    parameter int MAG_W         = 6,
    parameter int WIDE_CEIL     = 64,
    parameter int NARROW_CEIL   = 32,
    parameter int STATIC_OFFSET = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       freq_mode,
    input  logic [1:0]       ofs_src,
    input  logic             ofs_dir,
    input  logic [MAG_W-1:0] ofs_mag,
    input  logic [SET_W-1:0] dll_set,
    output logic [SET_W-1:0] dly_set,
    output logic             clamp_flag
);
    localparam int OFS_W = MAG_W + 2;

    state_e                  state_q, state_d;
    logic                    narrow;
    logic signed [OFS_W-1:0] ofs;
    logic [SET_W-1:0]        lim_res;
    logic                    lim_clamped;

    assign narrow = (freq_mode != 2'd0);

    dly_ofs_select #(
        .OFS_W(OFS_W), .MAG_W(MAG_W), .WIDE_CEIL(WIDE_CEIL),
        .NARROW_CEIL(NARROW_CEIL), .STATIC_OFFSET(STATIC_OFFSET)
    ) u_select (
        .narrow(narrow), .src(src_e'(ofs_src)), .dir(ofs_dir),
        .mag(ofs_mag), .ofs(ofs)
    );

    dly_range_limit #(
        .SET_W(SET_W), .OFS_W(OFS_W),
        .WIDE_CEIL(WIDE_CEIL), .NARROW_CEIL(NARROW_CEIL)
    ) u_limit (
        .dll(dll_set), .ofs(ofs), .narrow(narrow),
        .res(lim_res), .clamped(lim_clamped)
    );

    // State register: ANY_TO_RAW on reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RAW;
        else        state_q <= state_d;
    end

    // Next state: RAW_TO_ADJUST unconditionally
    always_comb begin
        unique case (state_q)
            ST_RAW:    state_d = ST_ADJUST;
            ST_ADJUST: state_d = ST_ADJUST;
            default:   state_d = ST_RAW;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_set    <= dll_set;
            clamp_flag <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RAW: begin
                    dly_set    <= dll_set;
                    clamp_flag <= 1'b0;
                end
                ST_ADJUST: begin
                    dly_set    <= lim_res;
                    clamp_flag <= lim_clamped;
                end
                default: begin
                    dly_set    <= dll_set;
                    clamp_flag <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dly_ofs_adjust_chk.sv
module dly_ofs_adjust_chk
    import dly_ofs_pkg::*;
#(
    parameter int SET_W       = 7,
    parameter int MAG_W       = 6,
    parameter int WIDE_CEIL   = 64,
    parameter int NARROW_CEIL = 32
) (
    input logic             clk,
    input logic             rst_n,
    input state_e           state_q,
    input logic [1:0]       freq_mode,
    input logic [1:0]       ofs_src,
    input logic [MAG_W-1:0] ofs_mag,
    input logic [SET_W-1:0] dll_set,
    input logic [SET_W-1:0] dly_set,
    input logic             clamp_flag
);
    localparam logic [SET_W-1:0] W_CEIL = SET_W'(WIDE_CEIL);
    localparam logic [SET_W-1:0] N_CEIL = SET_W'(NARROW_CEIL);

    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAW) |=> (dly_set == $past(dll_set) && !clamp_flag)); // R1

    AST_ADD_NOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && ofs_src == 2'd1 && dll_set <= N_CEIL)
        |=> (dly_set >= $past(dll_set))); // R3

    AST_SUB_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && ofs_src == 2'd2) |=> (dly_set <= $past(dll_set))); // R4

    AST_WIDE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST) |=> (dly_set <= W_CEIL)); // R8

    AST_NARROW_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && freq_mode != 2'd0) |=> (dly_set <= N_CEIL)); // R8

    AST_ZERO_MAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJUST && ofs_src != 2'd0 && ofs_mag == '0 && dll_set <= N_CEIL)
        |=> (dly_set == $past(dll_set) && !clamp_flag)); // R10

    AST_FLAG_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_flag |-> (dly_set == '0 || dly_set == W_CEIL || dly_set == N_CEIL)); // R10

endmodule

bind dly_ofs_adjust dly_ofs_adjust_chk #(
    .SET_W(SET_W), .MAG_W(MAG_W),
    .WIDE_CEIL(WIDE_CEIL), .NARROW_CEIL(NARROW_CEIL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .freq_mode(freq_mode),
    .ofs_src(ofs_src), .ofs_mag(ofs_mag), .dll_set(dll_set),
    .dly_set(dly_set), .clamp_flag(clamp_flag)
);

// File: tb/test_dly_ofs_adjust.sv
`timescale 1ns/1ps
module test_dly_ofs_adjust;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] freq_mode = '0;
    logic [1:0] ofs_src = '0;
    logic       ofs_dir = 1'b0;
    logic [5:0] ofs_mag = '0;
    logic [6:0] dll_set = '0;
    logic [6:0] dly_set;
    logic       clamp_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dly_ofs_adjust #(.STATIC_OFFSET(-40)) i_dly_ofs_adjust (
        .clk(clk), .rst_n(rst_n), .freq_mode(freq_mode), .ofs_src(ofs_src),
        .ofs_dir(ofs_dir), .ofs_mag(ofs_mag), .dll_set(dll_set),
        .dly_set(dly_set), .clamp_flag(clamp_flag)
    );

    // {src, mode, dir, mag, dll, expected setting, expected flag}; static trim is -40
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b0, 6'd0,  7'd50,  7'd10, 1'b0}, // R2 static, wide
        {2'd0, 2'd1, 1'b0, 6'd0,  7'd50,  7'd18, 1'b0}, // R2 static limited to -32
        {2'd0, 2'd0, 1'b0, 6'd0,  7'd30,  7'd0,  1'b1}, // R9 static below zero
        {2'd1, 2'd0, 1'b0, 6'd36, 7'd28,  7'd64, 1'b0}, // R3 R6 add to exact ceiling
        {2'd1, 2'd0, 1'b0, 6'd37, 7'd28,  7'd64, 1'b1}, // R8 one past ceiling
        {2'd1, 2'd2, 1'b0, 6'd40, 7'd10,  7'd32, 1'b1}, // R7 R8 narrow add limit 31
        {2'd1, 2'd3, 1'b0, 6'd31, 7'd0,   7'd31, 1'b0}, // R7 narrow add at limit
        {2'd2, 2'd0, 1'b0, 6'd28, 7'd28,  7'd0,  1'b0}, // R4 subtract to exact zero
        {2'd2, 2'd0, 1'b0, 6'd29, 7'd28,  7'd0,  1'b1}, // R9 one below zero
        {2'd2, 2'd1, 1'b0, 6'd63, 7'd40,  7'd8,  1'b0}, // R7 narrow subtract limit 32
        {2'd3, 2'd0, 1'b1, 6'd5,  7'd20,  7'd25, 1'b0}, // R5 dir=1 adds
        {2'd3, 2'd0, 1'b0, 6'd5,  7'd20,  7'd15, 1'b0}, // R5 dir=0 subtracts
        {2'd3, 2'd2, 1'b0, 6'd63, 7'd63,  7'd31, 1'b0}, // R5 R7 narrow subtract
        {2'd3, 2'd0, 1'b1, 6'd63, 7'd63,  7'd64, 1'b1}, // R6 R8 full wide add
        {2'd1, 2'd0, 1'b0, 6'd0,  7'd100, 7'd64, 1'b1}, // R8 raw above ceiling
        {2'd1, 2'd0, 1'b0, 6'd3,  7'd10,  7'd13, 1'b0}, // R3 dir ignored on add
        {2'd2, 2'd0, 1'b1, 6'd3,  7'd10,  7'd7,  1'b0}  // R4 dir ignored on subtract
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_check(input string req, input int eq, input int ef);
        @(posedge clk);
        #1;
        check({req, " setting"}, int'(dly_set), eq);
        check({req, " flag"}, int'(clamp_flag), ef);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: raw value during reset
        dll_set = 7'd77; ofs_src = 2'd1; ofs_mag = 6'd10; freq_mode = 2'd0;
        @(posedge clk); @(posedge clk); #1;
        check("R1 reset setting", int'(dly_set), 77);
        check("R1 reset flag", int'(clamp_flag), 0);
        @(negedge clk) rst_n = 1'b1;
        step_check("R1 first cycle raw", 77, 0);
        step_check("R8 first adjusted", 64, 1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ofs_src   = VEC[i][25:24];
            freq_mode = VEC[i][23:22];
            ofs_dir   = VEC[i][21];
            ofs_mag   = VEC[i][20:15];
            dll_set   = VEC[i][14:8];
            step_check($sformatf("vector %0d", i), int'(VEC[i][7:1]), int'(VEC[i][0]));
        end

        // R11: mode change takes effect on the next clock
        @(negedge clk);
        ofs_src = 2'd1; freq_mode = 2'd0; dll_set = 7'd30; ofs_mag = 6'd20;
        step_check("R11 wide sum", 50, 0);
        @(negedge clk) freq_mode = 2'd1;
        step_check("R11 narrow after mode change", 32, 1);
        // R10: flag drops as soon as no clamp occurs
        @(negedge clk) ofs_mag = 6'd0;
        step_check("R10 flag clears", 30, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule